// File: doc/BRIEF.md
# Packed Integer-to-Float Converter Unit

This unit turns a pair of signed 32-bit integers, packed side by side in a 64-bit source word, into two IEEE-754 single-precision values. Each result goes into its own 32-bit lane of the low half of a 128-bit destination. The upper 64 bits of the destination are copied through from the prior destination value that comes with the request. When a magnitude needs more than 24 significant bits, the result is rounded under a 2-bit rounding-mode input. A precision flag reports that at least one lane lost bits.

A request is one clock with `start_i` high. One clock later the merged 128-bit result, the precision flag and a one-cycle `done_o` pulse appear. Each operation also tells the register-stack logic to reset: `stk_wr_o` pulses, the 3-bit stack-top value is 0 and the 16-bit tag word is all zeros, which marks every entry valid. Result and flag hold their values until the next request.

Top module: `i2f_pair_unit`

## Requirements
- R1: Source bits [31:0] convert into result bits [31:0]. Source bits [63:32] convert into result bits [63:32]. Each lane is packed as {sign at bit 31, biased exponent (bias 127) in bits 30:23, fraction in bits 22:0}.
- R2: Result bits [127:64] equal bits [127:64] of `dst_i` as sampled with the request.
- R3: Each source lane is a two's-complement signed integer. -2^31 converts exactly to 0xCF000000, and negative inputs carry the sign bit set.
- R4: An input of zero gives 0x00000000 (+0.0) and does not make the precision flag rise.
- R5: When the magnitude does not fit in 24 significant bits, `rmode_i` selects the rounding: 00 nearest with ties to even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero.
- R6: A rounding carry out of the 24-bit significand raises the exponent by one and clears the fraction. For example, 0x7FFFFFFF under mode 00 gives 0x4F000000.
- R7: `inexact_o` is the OR of both lanes' inexact conditions for the latest request. A lane is inexact when any discarded magnitude bit is set.
- R8: `done_o` is high exactly in the cycle after a cycle with `start_i` high. Without a request, `res_o` and `inexact_o` hold their values.
- R9: In every cycle where `done_o` is high, `stk_wr_o` is high, `stk_top_o` is 0 and `stk_tag_o` is all zeros.
- R10: After reset, `res_o`, `inexact_o`, `done_o` and `stk_wr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, one cycle per conversion |
| rmode_i | input | 2 | Rounding mode (00 nearest-even, 01 down, 10 up, 11 toward zero) |
| src_i | input | 64 | Two packed signed 32-bit integers |
| dst_i | input | 128 | Prior destination value; upper half is kept |
| res_o | output | 128 | Merged result |
| inexact_o | output | 1 | Precision flag of the latest request |
| done_o | output | 1 | One-cycle completion pulse |
| stk_wr_o | output | 1 | Stack-reset strobe, aligned with done_o |
| stk_top_o | output | 3 | Stack-top value to load (0) |
| stk_tag_o | output | 16 | Tag word to load (all zeros = valid) |

## Verification
Two functions can fall in the same cycle. The first is a rounding carry that bumps a lane's exponent. The second is the precision flag, which has to merge that lane's inexact condition with the other lane's, even when the other lane is exact. The bench provokes both at once by sweeping each power of two from 2^0 to 2^31 with offsets of -2 to +2 and both signs, under all four modes. A value just below a large power of two sits in one lane while the other lane holds a small exact value or a random one. Every lane word, the exponent after the carry, and the flag as the OR of the two lanes are compared against a conversion the bench computes with plain integer arithmetic.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

    localparam int LANE_W   = 32;
    localparam int SIG_W    = 24;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = SIG_W - 1;
    localparam int EXP_BIAS = 127;
    localparam int LZ_W     = $clog2(LANE_W) + 1;
    localparam int TOS_W    = 3;
    localparam int TAG_W    = 16;
    localparam int EXP_TOP  = EXP_BIAS + LANE_W - 1;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic              sign;
        logic              zero;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        logic              guard;
        logic              rnd;
        logic              sticky;
    } norm_t;

    typedef struct packed {
        logic [LANE_W-1:0] bits;
        logic              inexact;
    } lane_out_t;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [LANE_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            hit;
        n   = LZ_W'(LANE_W);
        hit = 1'b0;
        for (int i = LANE_W - 1; i >= 0; i--) begin
            if (!hit && v[i]) begin
                n   = LZ_W'(LANE_W - 1 - i);
                hit = 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/i2f_normalize.sv
module i2f_normalize
    import i2f_pkg::*;
(
    input  logic [LANE_W-1:0] val_i,
    output norm_t             norm_o
);
    logic [LANE_W-1:0] mag;
    logic [LZ_W-1:0]   lz;
    logic [LANE_W-1:0] shifted;
    localparam int LOW_W = LANE_W - SIG_W;

    always_comb begin
        mag     = val_i[LANE_W-1] ? (~val_i + 1'b1) : val_i;
        lz      = lead_zeros(mag);
        shifted = mag << lz[LZ_W-2:0];
        norm_o.sign   = val_i[LANE_W-1];
        norm_o.zero   = (mag == '0);
        norm_o.exp    = EXP_W'(EXP_TOP) - EXP_W'(lz);
        norm_o.sig    = shifted[LANE_W-1 -: SIG_W];
        norm_o.guard  = shifted[LOW_W-1];
        norm_o.rnd    = shifted[LOW_W-2];
        norm_o.sticky = |shifted[LOW_W-3:0];
    end
endmodule

// File: rtl/i2f_rounder.sv
module i2f_rounder
    import i2f_pkg::*;
(
    input  norm_t     norm_i,
    input  rmode_e    rmode_i,
    output lane_out_t out_o
);
    logic             lost;
    logic             bump;
    logic [SIG_W:0]   sum;
    logic [EXP_W-1:0] exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        lost = norm_i.guard | norm_i.rnd | norm_i.sticky;
        unique case (rmode_i)
            RM_NEAR: bump = norm_i.guard & (norm_i.rnd | norm_i.sticky | norm_i.sig[0]);
            RM_DOWN: bump = lost & norm_i.sign;
            RM_UP:   bump = lost & ~norm_i.sign;
            default: bump = 1'b0;
        endcase
        sum    = {1'b0, norm_i.sig} + (SIG_W+1)'(bump);
        exp_f  = norm_i.exp + EXP_W'(sum[SIG_W]);
        frac_f = sum[SIG_W] ? '0 : sum[FRAC_W-1:0];
        if (norm_i.zero) begin
            out_o.bits    = '0;
            out_o.inexact = 1'b0;
        end else begin
            out_o.bits    = {norm_i.sign, exp_f, frac_f};
            out_o.inexact = lost;
        end
    end
endmodule

// File: rtl/i2f_lane.sv
module i2f_lane
    import i2f_pkg::*;
(
    input  logic [LANE_W-1:0] val_i,
    input  rmode_e            rmode_i,
    output lane_out_t         out_o
);
    norm_t norm;

    i2f_normalize u_norm (
        .val_i  (val_i),
        .norm_o (norm)
    );

    i2f_rounder u_round (
        .norm_i  (norm),
        .rmode_i (rmode_i),
        .out_o   (out_o)
    );
endmodule

// File: rtl/i2f_pair_unit.sv
module i2f_pair_unit
    import i2f_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic [1:0]               rmode_i,
    input  logic [LANES*LANE_W-1:0]  src_i,
    input  logic [2*LANES*LANE_W-1:0] dst_i,
    output logic [2*LANES*LANE_W-1:0] res_o,
    output logic                     inexact_o,
    output logic                     done_o,
    output logic                     stk_wr_o,
    output logic [TOS_W-1:0]         stk_top_o,
    output logic [TAG_W-1:0]         stk_tag_o
);
    localparam int SRC_W = LANES * LANE_W;
    localparam int DST_W = 2 * SRC_W;

    rmode_e             mode;
    lane_out_t          lane_res [LANES];
    logic [SRC_W-1:0]   low_next;
    logic [LANES-1:0]   inex_vec;

    assign mode = rmode_e'(rmode_i);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        i2f_lane u_lane (
            .val_i   (src_i[g*LANE_W +: LANE_W]),
            .rmode_i (mode),
            .out_o   (lane_res[g])
        );
        assign low_next[g*LANE_W +: LANE_W] = lane_res[g].bits;
        assign inex_vec[g]                  = lane_res[g].inexact;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o     <= '0;
            inexact_o <= 1'b0;
            done_o    <= 1'b0;
            stk_wr_o  <= 1'b0;
            stk_top_o <= '0;
            stk_tag_o <= '0;
        end else begin
            done_o   <= start_i;
            stk_wr_o <= start_i;
            if (start_i) begin
                res_o     <= {dst_i[DST_W-1:SRC_W], low_next};
                inexact_o <= |inex_vec;
                stk_top_o <= '0;
                stk_tag_o <= '0;
            end
        end
    end
endmodule

// File: rtl/i2f_pair_chk.sv
module i2f_pair_chk
    import i2f_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start_i,
    input logic [1:0]                rmode_i,
    input logic [LANES*LANE_W-1:0]   src_i,
    input logic [2*LANES*LANE_W-1:0] dst_i,
    input logic [2*LANES*LANE_W-1:0] res_o,
    input logic                      inexact_o,
    input logic                      done_o,
    input logic                      stk_wr_o,
    input logic [TOS_W-1:0]          stk_top_o,
    input logic [TAG_W-1:0]          stk_tag_o
);
    localparam int SRC_W = LANES * LANE_W;
    localparam int DST_W = 2 * SRC_W;

    // R8
    done_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> !done_o);

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> ($stable(res_o) && $stable(inexact_o)));

    // R9
    stack_reset_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (stk_wr_o && stk_top_o == '0 && stk_tag_o == '0));

    // R2
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (res_o[DST_W-1:SRC_W] == $past(dst_i[DST_W-1:SRC_W])));

    // R4
    zero_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && src_i[LANE_W-1:0] == '0) |=> (res_o[LANE_W-1:0] == '0));

    // R3
    sign_follow_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (res_o[LANE_W-1] == $past(src_i[LANE_W-1])));
endmodule

bind i2f_pair_unit i2f_pair_chk u_chk (.*);

// File: tb/i2f_pair_unit_test.sv
`timescale 1ns/1ps
module i2f_pair_unit_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         start_i;
    logic [1:0]   rmode_i;
    logic [63:0]  src_i;
    logic [127:0] dst_i;
    logic [127:0] res_o;
    logic         inexact_o;
    logic         done_o;
    logic         stk_wr_o;
    logic [2:0]   stk_top_o;
    logic [15:0]  stk_tag_o;

    int tests  = 0;
    int failed = 0;
    int cycles = 0;

    i2f_pair_unit uut (.*);

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failed++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests + 1, failed);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Arithmetic model: find top bit, divide, compare remainder to half
    task automatic ref_cvt(input logic [31:0] x, input logic [1:0] rm,
                           output logic [31:0] bits, output logic inex);
        longint m, q, rem, half;
        int     e, sh;
        bit     neg, up;
        neg = x[31];
        m = neg ? (64'h1_0000_0000 - longint'({32'b0, x})) : longint'({32'b0, x});
        inex = 1'b0;
        if (m == 0) begin
            bits = 32'h0;
            return;
        end
        e = 0;
        for (int i = 0; i < 33; i++) if (m >= (64'sd1 <<< i)) e = i;
        if (e <= 23) begin
            q = m <<< (23 - e);
        end else begin
            sh   = e - 23;
            q    = m >>> sh;
            rem  = m - (q <<< sh);
            half = 64'sd1 <<< (sh - 1);
            inex = (rem != 0);
            case (rm)
                2'b00:   up = (rem > half) || (rem == half && q[0]);
                2'b01:   up = inex && neg;
                2'b10:   up = inex && !neg;
                default: up = 1'b0;
            endcase
            if (up) q = q + 1;
            if (q == (64'sd1 <<< 24)) begin
                q = q >>> 1;
                e = e + 1;
            end
        end
        bits = {neg, 8'(e + 127), q[22:0]};
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input logic [1:0] rm, input logic [127:0] d);
        logic [31:0] ea, eb;
        logic        ia, ib;
        ref_cvt(a, rm, ea, ia);
        ref_cvt(b, rm, eb, ib);
        @(negedge clk);
        start_i = 1'b1;
        rmode_i = rm;
        src_i   = {b, a};
        dst_i   = d;
        @(negedge clk);
        start_i = 1'b0;
        src_i   = ~src_i;
        dst_i   = ~dst_i;
        check(done_o == 1'b1, "R8 done after start", 128'(done_o), 128'd1);
        check(res_o[31:0] == ea, "R1/R3/R5 lane0", 128'(res_o[31:0]), 128'(ea));
        check(res_o[63:32] == eb, "R1/R3/R5 lane1", 128'(res_o[63:32]), 128'(eb));
        check(res_o[127:64] == d[127:64], "R2 upper half kept", res_o[127:64], d[127:64]);
        check(inexact_o == (ia | ib), "R7 flag OR of lanes", 128'(inexact_o), 128'(ia | ib));
        check(stk_wr_o && stk_top_o == 3'd0 && stk_tag_o == 16'd0, "R9 stack reset",
              {stk_wr_o, stk_top_o, stk_tag_o}, {1'b1, 19'd0});
        @(negedge clk);
        check(done_o == 1'b0, "R8 single-cycle done", 128'(done_o), 128'd0);
        check(res_o[63:0] == {eb, ea}, "R8 result holds", 128'(res_o[63:0]), 128'({eb, ea}));
    endtask

    initial begin
        logic [127:0] rnd_d;
        rst     = 1'b1;
        start_i = 1'b0;
        rmode_i = 2'b00;
        src_i   = '0;
        dst_i   = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(res_o == '0 && inexact_o == 1'b0, "R10 reset outputs", res_o, 128'd0);
        check(done_o == 1'b0 && stk_wr_o == 1'b0, "R10 reset strobes",
              128'({done_o, stk_wr_o}), 128'd0);

        // Directed boundaries, all modes
        for (int rm = 0; rm < 4; rm++) begin
            rnd_d = {$urandom, $urandom, $urandom, $urandom};
            // R4 zero in both lanes, no flag
            run_op(32'h0, 32'h0, 2'(rm), rnd_d);
            check(res_o[63:0] == 64'h0 && !inexact_o, "R4 zero lanes", 128'(res_o[63:0]), 128'd0);
            // R3 most negative
            run_op(32'h8000_0000, 32'h1, 2'(rm), rnd_d);
            check(res_o[31:0] == 32'hCF00_0000, "R3 -2^31 exact", 128'(res_o[31:0]), 128'h CF00_0000);
            // R6 carry into exponent
            run_op(32'h7FFF_FFFF, 32'h0100_0001, 2'(rm), rnd_d);
            run_op(32'hFEFF_FFFF, 32'h8000_0001, 2'(rm), rnd_d);
            // R7 exact lane0 with inexact lane1, and the reverse
            run_op(32'd5, 32'hFEFF_FFFF, 2'(rm), rnd_d);
            run_op(32'h0100_0003, 32'hFFFF_FFFF, 2'(rm), rnd_d);
        end
        // R6 explicit value
        run_op(32'h7FFF_FFFF, 32'h0, 2'b00, '0);
        check(res_o[31:0] == 32'h4F00_0000, "R6 carry 0x7FFFFFFF", 128'(res_o[31:0]), 128'h4F00_0000);
        // R5 mode encodings on +(2^24+1) and -(2^24+1)
        run_op(32'h0100_0001, 32'hFEFF_FFFF, 2'b10, '0);
        check(res_o[63:0] == {32'hCB80_0000, 32'h4B80_0001}, "R5 mode up",
              128'(res_o[63:0]), 128'({32'hCB80_0000, 32'h4B80_0001}));
        run_op(32'h0100_0001, 32'hFEFF_FFFF, 2'b01, '0);
        check(res_o[63:0] == {32'hCB80_0001, 32'h4B80_0000}, "R5 mode down",
              128'(res_o[63:0]), 128'({32'hCB80_0001, 32'h4B80_0000}));

        // Sweep around every power of two, both signs, all modes
        for (int rm = 0; rm < 4; rm++) begin
            for (int k = 0; k < 32; k++) begin
                for (int o = -2; o <= 2; o++) begin
                    for (int s = 0; s < 2; s++) begin
                        logic [31:0] v, w;
                        v = 32'((64'sd1 <<< k) + o);
                        if (s == 1) v = ~v + 1;
                        w = (k[0]) ? 32'(k * 3) : $urandom;
                        run_op(v, w, 2'(rm), {$urandom, $urandom, $urandom, $urandom});
                        run_op(w, v, 2'(rm), {$urandom, $urandom, $urandom, $urandom});
                    end
                end
            end
        end

        // Random pairs
        for (int n = 0; n < 600; n++) begin
            run_op($urandom, $urandom, 2'($urandom), {$urandom, $urandom, $urandom, $urandom});
        end

        // R8 back-to-back requests keep done high
        @(negedge clk);
        start_i = 1'b1;
        src_i   = {32'd7, 32'd9};
        @(negedge clk);
        src_i   = {32'd3, 32'd4};
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b1 && res_o[31:0] == 32'h4080_0000, "R8 back-to-back",
              128'({done_o, res_o[31:0]}), 128'({1'b1, 32'h4080_0000}));

        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule